// File: doc/BRIEF.md
# ADC Snapshot Capture Buffer

This block takes a one-shot burst of raw ADC samples and keeps it in an on-chip RAM. A host then reads the burst back in fixed-length segments. Commands arrive as a framed byte stream (valid, data, last). A two-byte start frame of 0x62 0x62 clears the ready flag and arms capture at address 0. Each qualified ADC sample after that is written to the next RAM location. When the last location has been written, capture stops by itself and the ready flag is set.

Any other command frame is a read request, and its last two bytes give the start address. The block answers on a response byte stream. The answer holds a sequence-number byte, a status byte that carries the ready flag, and then `SEG_LEN` samples. Each sample is widened to 16 bits and sent high byte first. The host walks the whole RAM by sending requests with rising start addresses.

Capture and readout share only the RAM, so a host can read while a capture is filling it. The block sits beside the receive datapath and does not touch it. The depth is 2^`ADDR_W`. A full 16K-sample buffer uses `ADDR_W` = 14, and the default is kept smaller.

Top module: `adc_snap`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_last` are low, the ready flag is 0, and the first response carries sequence number 0.
- R2: A command frame of exactly two bytes, both 0x62, starts a capture. It clears the ready flag and restarts writing at address 0, even when a capture is already running. It produces no response.
- R3: While capture runs, each cycle with `adc_valid` high writes `adc_data` to the next address, starting at 0. After address DEPTH-1 is written, capture halts and the ready flag is set. Later samples are ignored until the next start frame.
- R4: Every other command frame is a read request. The start address is the last two bytes of the frame, first byte as the high byte, with only the low `ADDR_W` bits kept. A one-byte frame uses that byte as the address.
- R5: A response is 2 + 2*`SEG_LEN` bytes (1442 by default) with `rsp_valid` high on consecutive cycles. `rsp_last` is high only on the final byte.
- R6: Response byte 0 is the sequence number. Byte 1 is the status byte: bit 0 is the ready flag and bits 7:1 are zero.
- R7: Payload byte pairs hold the samples at consecutive addresses from the start address. Each 14-bit sample is sign-extended to 16 bits and sent high byte first. Addresses past DEPTH-1 wrap to 0.
- R8: The sequence number goes up by one, modulo 256, after every response.
- R9: A read request whose last byte arrives while a response is still being sent is dropped. It gives no response and does not advance the sequence number.
- R10: A read issued during a capture returns the current RAM contents, with the ready flag at 0. Reads do not disturb an ongoing capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_valid | input | 1 | ADC sample strobe |
| adc_data | input | SAMPLE_W | Raw ADC sample, two's complement |
| cmd_valid | input | 1 | Command byte valid |
| cmd_data | input | 8 | Command byte |
| cmd_last | input | 1 | Final byte of a command frame |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of a response |

## Verification
A wrong write pointer or ready flag shows up in the very next response. Such a fault gives misplaced or missing samples in the payload, or a wrong bit 0 in the status byte. A stale or skipped sequence counter shows up in byte 0 of the following response. A broken read-address pipeline shifts every payload pair by one sample from the first pair onward. A fault in the parser turns a start frame into a response, or a read into a capture restart, and this is seen one response later at the latest.

// File: rtl/adc_snap_pkg.sv
package adc_snap_pkg;
   localparam logic [7:0] ARM_BYTE = 8'h62;
   localparam int WORD_W = 16;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SEQ,
      PH_STAT,
      PH_HI,
      PH_LO
   } rsp_phase_e;
endpackage

// File: rtl/adc_snap_cmd.sv
module adc_snap_cmd
   import adc_snap_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_data,
   input  logic              cmd_last,
   output logic              arm_pulse,
   output logic              read_pulse,
   output logic [ADDR_W-1:0] read_addr
);
   logic [15:0] acc_q;
   logic [15:0] acc_nx;
   logic [1:0]  cnt_q;
   logic [1:0]  cnt_nx;
   logic        frame_end;

   always_comb begin
      acc_nx    = {acc_q[7:0], cmd_data};
      cnt_nx    = (cnt_q == 2'd3) ? 2'd3 : cnt_q + 2'd1;
      frame_end = cmd_valid && cmd_last;
   end

   assign arm_pulse  = frame_end && (cnt_nx == 2'd2) && (acc_nx == {ARM_BYTE, ARM_BYTE});
   assign read_pulse = frame_end && !arm_pulse;
   assign read_addr  = acc_nx[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (cmd_valid) begin
         if (cmd_last) begin
            acc_q <= '0;
            cnt_q <= '0;
         end else begin
            acc_q <= acc_nx;
            cnt_q <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/adc_snap_capture.sv
module adc_snap_capture #(
   parameter int SAMPLE_W = 14,
   parameter int ADDR_W   = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm,
   input  logic                adc_valid,
   input  logic [SAMPLE_W-1:0] adc_data,
   output logic                wr_en,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [SAMPLE_W-1:0] wr_data,
   output logic                ready
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

   logic active_q;

   assign wr_en   = active_q && adc_valid && !arm;
   assign wr_data = adc_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         wr_addr  <= '0;
         ready    <= 1'b0;
      end else if (arm) begin
         active_q <= 1'b1;
         wr_addr  <= '0;
         ready    <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == LAST_ADDR) begin
            active_q <= 1'b0;
            ready    <= 1'b1;
         end else begin
            wr_addr <= wr_addr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_snap_ram.sv
module adc_snap_ram #(
   parameter int DATA_W = 14,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [ADDR_W-1:0] ra,
   output logic [DATA_W-1:0] rq
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      rq <= mem[ra];
   end
endmodule

// File: rtl/adc_snap_resp.sv
module adc_snap_resp
   import adc_snap_pkg::*;
#(
   parameter int SAMPLE_W = 14,
   parameter int ADDR_W   = 12,
   parameter int SEG_LEN  = 720,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                ready,
   output logic [ADDR_W-1:0]   rd_addr,
   input  logic [SAMPLE_W-1:0] rd_data,
   output logic                rsp_valid,
   output logic [7:0]          rsp_data,
   output logic                rsp_last,
   output logic [7:0]          seq_cur
);
   localparam int CNT_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SEG_LEN - 1);

   rsp_phase_e        phase_q;
   logic [CNT_W-1:0]  samp_q;
   logic [7:0]        lo_hold_q;
   logic [WORD_W-1:0] word;

   generate
      if (SAMPLE_W == WORD_W) begin : g_full
         assign word = rd_data;
      end else if (SIGN_EXT) begin : g_sext
         assign word = {{(WORD_W-SAMPLE_W){rd_data[SAMPLE_W-1]}}, rd_data};
      end else begin : g_zext
         assign word = {{(WORD_W-SAMPLE_W){1'b0}}, rd_data};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         samp_q    <= '0;
         lo_hold_q <= '0;
         rd_addr   <= '0;
         seq_cur   <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_last  <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         rsp_last  <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (req) begin
                  rd_addr <= req_addr;
                  samp_q  <= '0;
                  phase_q <= PH_SEQ;
               end
            end
            PH_SEQ: begin
               rsp_valid <= 1'b1;
               rsp_data  <= seq_cur;
               phase_q   <= PH_STAT;
            end
            PH_STAT: begin
               rsp_valid <= 1'b1;
               rsp_data  <= {7'd0, ready};
               phase_q   <= PH_HI;
            end
            PH_HI: begin
               rsp_valid <= 1'b1;
               rsp_data  <= word[15:8];
               lo_hold_q <= word[7:0];
               rd_addr   <= rd_addr + 1'b1;
               phase_q   <= PH_LO;
            end
            PH_LO: begin
               rsp_valid <= 1'b1;
               rsp_data  <= lo_hold_q;
               if (samp_q == CNT_END) begin
                  rsp_last <= 1'b1;
                  seq_cur  <= seq_cur + 8'd1;
                  phase_q  <= PH_IDLE;
               end else begin
                  samp_q  <= samp_q + 1'b1;
                  phase_q <= PH_HI;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_snap.sv
module adc_snap #(
   parameter int SAMPLE_W = 14,
   parameter int ADDR_W   = 12,
   parameter int SEG_LEN  = 720,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adc_valid,
   input  logic [SAMPLE_W-1:0] adc_data,
   input  logic                cmd_valid,
   input  logic [7:0]          cmd_data,
   input  logic                cmd_last,
   output logic                rsp_valid,
   output logic [7:0]          rsp_data,
   output logic                rsp_last
);
   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 16) begin : g_bad_width
         $error("adc_snap: SAMPLE_W must lie in 2..16");
      end
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
         $error("adc_snap: ADDR_W must lie in 2..16");
      end
      if (SEG_LEN < 1) begin : g_bad_seg
         $error("adc_snap: SEG_LEN must be positive");
      end
   endgenerate

   logic                arm_pulse;
   logic                read_pulse;
   logic [ADDR_W-1:0]   read_addr;
   logic                wr_en;
   logic [ADDR_W-1:0]   wr_addr;
   logic [SAMPLE_W-1:0] wr_data;
   logic                cap_ready;
   logic [ADDR_W-1:0]   rd_addr;
   logic [SAMPLE_W-1:0] rd_data;
   logic [7:0]          seq_cur;

   adc_snap_cmd #(.ADDR_W(ADDR_W)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_data   (cmd_data),
      .cmd_last   (cmd_last),
      .arm_pulse  (arm_pulse),
      .read_pulse (read_pulse),
      .read_addr  (read_addr)
   );

   adc_snap_capture #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm_pulse),
      .adc_valid (adc_valid),
      .adc_data  (adc_data),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .ready     (cap_ready)
   );

   adc_snap_ram #(.DATA_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_ram (
      .clk (clk),
      .we  (wr_en),
      .wa  (wr_addr),
      .wd  (wr_data),
      .ra  (rd_addr),
      .rq  (rd_data)
   );

   adc_snap_resp #(
      .SAMPLE_W (SAMPLE_W),
      .ADDR_W   (ADDR_W),
      .SEG_LEN  (SEG_LEN),
      .SIGN_EXT (SIGN_EXT)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (read_pulse),
      .req_addr  (read_addr),
      .ready     (cap_ready),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .rsp_last  (rsp_last),
      .seq_cur   (seq_cur)
   );
endmodule

// File: rtl/adc_snap_chk.sv
module adc_snap_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rsp_valid,
   input logic [7:0]        rsp_data,
   input logic              rsp_last,
   input logic              arm_pulse,
   input logic              ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        seq_cur
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   assert_last_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last |-> rsp_valid);

   assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_last) |=> rsp_valid);

   assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arm_pulse |=> !ready);

   assert_full_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (wr_addr == TOP_ADDR));

   assert_ready_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !arm_pulse) |=> ready);

   assert_seq_first_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> (rsp_data == seq_cur));

   assert_seq_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last |-> (seq_cur == $past(seq_cur) + 8'd1));
endmodule

bind adc_snap adc_snap_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rsp_valid (rsp_valid),
   .rsp_data  (rsp_data),
   .rsp_last  (rsp_last),
   .arm_pulse (arm_pulse),
   .ready     (cap_ready),
   .wr_addr   (wr_addr),
   .seq_cur   (seq_cur)
);

// File: tb/adc_snap_test.sv
`timescale 1ns/1ps
module adc_snap_test;
   localparam int SAMPLE_W = 14;
   localparam int ADDR_W   = 12;
   localparam int DEPTH    = 1 << ADDR_W;
   localparam int SEG_LEN  = 720;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                adc_valid = 1'b0;
   logic [SAMPLE_W-1:0] adc_data = '0;
   logic                cmd_valid = 1'b0;
   logic [7:0]          cmd_data = '0;
   logic                cmd_last = 1'b0;
   logic                rsp_valid;
   logic [7:0]          rsp_data;
   logic                rsp_last;

   always #4 clk = ~clk;

   adc_snap #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .SEG_LEN(SEG_LEN)) uut (
      .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_data(adc_data),
      .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_last(cmd_last),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
   );

   int checks = 0;
   int fails  = 0;

   // scoreboard entries: {care, last, data}
   logic [9:0] exp_q[$];
   string      tag_q[$];

   logic [SAMPLE_W-1:0] mm [DEPTH];
   bit        m_active = 0;
   int        m_waddr  = 0;
   bit        m_ready  = 0;
   logic [7:0] m_seq   = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [SAMPLE_W-1:0] gen(input int k, input int i);
      return SAMPLE_W'(i * 97 + k * 1231 + 5000);
   endfunction

   task automatic push(input bit care, input bit last, input logic [7:0] d, input string tag);
      exp_q.push_back({care, last, d});
      tag_q.push_back(tag);
   endtask

   // R5 R6 R7 R8: expected response built from the model
   task automatic expect_read(input int addr, input bit data_known, input string hdr_tag);
      push(1'b1, 1'b0, m_seq, hdr_tag);
      push(1'b1, 1'b0, {7'd0, m_ready}, hdr_tag);
      for (int j = 0; j < SEG_LEN; j++) begin
         logic [SAMPLE_W-1:0] s;
         logic [15:0] w;
         s = mm[(addr + j) % DEPTH];
         w = {{(16-SAMPLE_W){s[SAMPLE_W-1]}}, s};
         push(data_known, 1'b0, w[15:8], "R7");
         push(data_known, j == SEG_LEN - 1, w[7:0], "R5/R7");
      end
      m_seq = m_seq + 8'd1;
   endtask

   task automatic send3(input int n, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input bit answered, input bit data_known,
                        input string tag);
      logic [7:0] b[3];
      int addr;
      b[0] = b0; b[1] = b1; b[2] = b2;
      if (n == 1) addr = b0;
      else addr = {b[n-2], b[n-1]};
      addr = addr % DEPTH;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmd_valid = 1'b1;
         cmd_data  = b[i];
         cmd_last  = (i == n - 1);
      end
      if (n == 2 && b0 == 8'h62 && b1 == 8'h62) begin
         m_active = 1; m_waddr = 0; m_ready = 0;
      end else if (answered) begin
         expect_read(addr, data_known, tag);
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_last  = 1'b0;
   endtask

   task automatic arm();
      send3(2, 8'h62, 8'h62, 8'h00, 1'b0, 1'b0, "R2");
   endtask

   task automatic read_at(input int addr, input string tag);
      send3(2, 8'((addr >> 8) & 255), 8'(addr & 255), 8'h00, 1'b1, 1'b1, tag);
   endtask

   task automatic feed(input int k, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         adc_valid = 1'b1;
         adc_data  = gen(k, i);
         if (m_active) begin
            mm[m_waddr] = gen(k, i);
            if (m_waddr == DEPTH - 1) begin
               m_active = 0; m_ready = 1;
            end else begin
               m_waddr++;
            end
         end
      end
      @(negedge clk);
      adc_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   // monitor: pops expected bytes as the design produces them
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected byte", {23'd0, rsp_last, rsp_data}, 32'h0);
         end else begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rsp_last == e[8], "R5 last flag", {31'd0, rsp_last}, {31'd0, e[8]});
            if (e[9]) check(rsp_data == e[7:0], t, {24'd0, rsp_data}, {24'd0, e[7:0]});
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1: quiet outputs after reset
      check(rsp_valid == 1'b0 && rsp_last == 1'b0, "R1 outputs idle",
            {30'd0, rsp_valid, rsp_last}, 32'd0);
      // R1: first answer has sequence 0 and ready 0; payload unknown
      send3(2, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R1");
      wait_idle();

      // R2 R3: full capture, surplus samples ignored
      arm();
      feed(0, DEPTH + 40);
      read_at(0, "R3");
      wait_idle();
      // R7: wrap past the top address
      read_at(DEPTH - 300, "R7");
      wait_idle();
      // R4: high address bits dropped
      send3(2, 8'hF0, 8'h05, 8'h00, 1'b1, 1'b1, "R4");
      wait_idle();
      // R4: three-byte frame ending in 0x62 0x62 is a read, not a start
      send3(3, 8'h00, 8'h62, 8'h62, 1'b1, 1'b1, "R4");
      wait_idle();
      // R4: one-byte frame
      send3(1, 8'h2A, 8'h00, 8'h00, 1'b1, 1'b1, "R4");
      wait_idle();

      // R9: request during an active response is dropped
      read_at(100, "R9");
      repeat (200) @(negedge clk);
      send3(2, 8'h00, 8'h10, 8'h00, 1'b0, 1'b0, "R9");
      wait_idle();
      check(rsp_valid == 1'b0, "R9 no extra response", {31'd0, rsp_valid}, 32'd0);
      read_at(7, "R8");
      wait_idle();

      // R10: read during capture sees partial contents and ready 0
      arm();
      feed(1, 100);
      read_at(0, "R10");
      wait_idle();
      feed(1, DEPTH);
      read_at(DEPTH - 50, "R10");
      wait_idle();

      // R2: restart in the middle of a capture
      arm();
      feed(2, 50);
      arm();
      feed(3, 30);
      read_at(0, "R2");
      wait_idle();

      check(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 32'd0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule